// File: doc/BRIEF.md
# SD card clock divider

This block produces the clock sent to an SD or MMC card from a fixed 96 MHz reference. The reference runs the whole block. A 10-bit integer divider sets the card clock rate. Control comes from three plain inputs: a divider value, an enable that starts the internal divided clock, and an enable for the card clock output. The block returns a flag that reports when the internal clock has settled. Software, or a sequencer upstream, sets the card clock enable only after that flag goes high.

To change frequency, the driver first clears both enables. It then loads the new divider value and sets the internal enable again. It waits for the settled flag before it re-enables the card clock. The block captures the divider on the rising edge of the internal enable. A divider of 0 or 1 passes the reference straight through.

A separate combinational helper turns a target frequency in hertz into the divider to program. It rounds the divider up so that the card clock never exceeds the target. A target of 400 kHz gives 240, which is the card identification rate. None of the interfaces carries a data stream, so every pin is a plain level signal.

Top module: `sdclk_gen`

## Requirements
- R1: During and right after reset, `clk_stable` is 0 and `card_clk` is 0.
- R2: With a captured divider N of 2 or more, `card_clk` has a period of exactly N reference cycles. It is high for floor(N/2) cycles and low for the remaining N - floor(N/2).
- R3: With a captured divider of 0 or 1, `card_clk` follows the reference clock: high in its high phase and low in its low phase.
- R4: `ice_en` may rise with the block idle. Call E0 the first reference rising edge at which it is sampled high. `clk_stable` is 0 through edge E3 and becomes 1 after edge E4, a fixed 4 cycles.
- R5: `clk_stable` goes to 0 in the same cycle that `ice_en` is cleared, with no clock edge needed. `card_clk` then stays low.
- R6: `card_clk` stays low while `clk_stable` is 0, even if `card_en` is 1.
- R7: In divided mode the card clock gate opens and closes only during a low phase of the divided clock. Every high pulse on `card_clk` therefore has the full floor(N/2) length, at whatever moment `card_en` toggles.
- R8: `div_val` is captured only at edge E0. Changes to it while `ice_en` stays high do not affect `card_clk` until the internal enable is cleared and set again.
- R9: `calc_div` returns 0 when `calc_target_hz` is 0. Otherwise it returns q = floor(96e6 / target), plus 1 when 96e6 / q exceeds the target. A q of 0 stays 0. The result saturates at 1023. For example, 400000 gives 240, 25000000 gives 4 and 52000000 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 96 MHz reference clock; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ice_en | input | 1 | Internal clock enable; a rising edge captures the divider and restarts the divider |
| card_en | input | 1 | Card clock output enable |
| div_val | input | 10 | Divider value; 0 and 1 select bypass |
| clk_stable | output | 1 | Internal divided clock has settled |
| card_clk | output | 1 | Clock to the card |
| calc_target_hz | input | 32 | Target card frequency in Hz for the helper |
| calc_div | output | 10 | Divider computed by the helper |

## Verification
The hardest condition to reach is a change of `card_en` while the divided clock is in its high phase. The only safe response is to hold the gate until the next low phase. The bench runs a divider of 8 and toggles `card_en` at cycle offsets that do not line up with the divided period. A monitor runs alongside and measures every complete high pulse, so a gate that opens or closes mid-pulse shows up as a short run. It also changes `div_val` while the clock runs and confirms that the period holds until a restart.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned DIV_W_DEF    = 10;
  localparam int unsigned SETTLE_DEF   = 4;
  localparam int unsigned REF_HZ_DEF   = 96_000_000;
  localparam int unsigned HZ_W         = 32;
endpackage

// File: rtl/sdclk_divcnt.sv
module sdclk_divcnt #(
  parameter int unsigned DIV_W = sdclk_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_in,
  output logic             start_p,
  output logic             run_q,
  output logic [DIV_W-1:0] div_lat,
  output logic             bypass,
  output logic             phase_q
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] last;

  assign start_p = run_en & ~run_q;
  assign bypass  = (div_lat < DIV_W'(2));
  assign half    = div_lat >> 1;
  assign last    = div_lat - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      div_lat <= '0;
      cnt     <= '0;
      phase_q <= 1'b0;
    end else begin
      run_q <= run_en;
      if (!run_en) begin
        cnt     <= '0;
        phase_q <= 1'b0;
      end else if (start_p) begin
        div_lat <= div_in;
        cnt     <= '0;
        phase_q <= 1'b0;
      end else if (!bypass) begin
        cnt     <= (cnt == last) ? '0 : cnt + DIV_W'(1);
        phase_q <= (cnt < half);
      end else begin
        phase_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int unsigned SETTLE = sdclk_pkg::SETTLE_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic run_q,
  input  logic start_p,
  output logic stable
);
  localparam int unsigned TW = $clog2(SETTLE + 1);
  localparam logic [TW-1:0] LIMIT = TW'(SETTLE);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!run_en || start_p) begin
      tcnt <= '0;
    end else if (tcnt != LIMIT) begin
      tcnt <= tcnt + TW'(1);
    end
  end

  assign stable = run_en & run_q & (tcnt == LIMIT);
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic phase_q,
  input  logic bypass,
  output logic gate_div,
  output logic card_clk
);
  logic gate_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_div <= 1'b0;
    end else if (!phase_q) begin
      gate_div <= want;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_byp <= 1'b0;
    end else begin
      gate_byp <= want;
    end
  end

  assign card_clk = bypass ? (clk & gate_byp) : (phase_q & gate_div);
endmodule

// File: rtl/sdclk_divcalc.sv
module sdclk_divcalc #(
  parameter int unsigned REF_HZ = sdclk_pkg::REF_HZ_DEF,
  parameter int unsigned DIV_W  = sdclk_pkg::DIV_W_DEF
) (
  input  logic [sdclk_pkg::HZ_W-1:0] target_hz,
  output logic [DIV_W-1:0]           div_out
);
  localparam int unsigned HW = sdclk_pkg::HZ_W;
  localparam logic [HW-1:0] REF_V   = HW'(REF_HZ);
  localparam logic [HW-1:0] MAX_DIV = HW'((1 << DIV_W) - 1);

  logic [HW-1:0] quo;
  logic [HW-1:0] back;
  logic [HW-1:0] adj;

  always_comb begin
    quo  = '0;
    back = '0;
    adj  = '0;
    if (target_hz != '0) begin
      quo  = REF_V / target_hz;
      back = (quo != '0) ? (REF_V / quo) : '0;
      adj  = (quo != '0 && back > target_hz) ? quo + HW'(1) : quo;
    end
    div_out = (adj > MAX_DIV) ? MAX_DIV[DIV_W-1:0] : adj[DIV_W-1:0];
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int unsigned DIV_W  = sdclk_pkg::DIV_W_DEF,
  parameter int unsigned SETTLE = sdclk_pkg::SETTLE_DEF,
  parameter int unsigned REF_HZ = sdclk_pkg::REF_HZ_DEF
) (
  input  logic                       ref_clk,
  input  logic                       rst_n,
  input  logic                       ice_en,
  input  logic                       card_en,
  input  logic [DIV_W-1:0]           div_val,
  output logic                       clk_stable,
  output logic                       card_clk,
  input  logic [sdclk_pkg::HZ_W-1:0] calc_target_hz,
  output logic [DIV_W-1:0]           calc_div
);
  logic             start_p;
  logic             run_q;
  logic [DIV_W-1:0] div_lat;
  logic             bypass;
  logic             phase_q;
  logic             gate_div;
  logic             want;

  sdclk_divcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(ref_clk), .rst_n(rst_n), .run_en(ice_en), .div_in(div_val),
    .start_p(start_p), .run_q(run_q), .div_lat(div_lat),
    .bypass(bypass), .phase_q(phase_q)
  );

  sdclk_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(ref_clk), .rst_n(rst_n), .run_en(ice_en), .run_q(run_q),
    .start_p(start_p), .stable(clk_stable)
  );

  assign want = card_en & clk_stable;

  sdclk_gate u_gate (
    .clk(ref_clk), .rst_n(rst_n), .want(want), .phase_q(phase_q),
    .bypass(bypass), .gate_div(gate_div), .card_clk(card_clk)
  );

  sdclk_divcalc #(.REF_HZ(REF_HZ), .DIV_W(DIV_W)) u_calc (
    .target_hz(calc_target_hz), .div_out(calc_div)
  );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int unsigned DIV_W  = sdclk_pkg::DIV_W_DEF,
  parameter int unsigned SETTLE = sdclk_pkg::SETTLE_DEF
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             ice_en,
  input logic             clk_stable,
  input logic             start_p,
  input logic             run_q,
  input logic [DIV_W-1:0] div_lat,
  input logic             phase_q,
  input logic             gate_div,
  input logic             want
);
  localparam int unsigned AW = $clog2(SETTLE + 2);
  localparam logic [AW-1:0] ACAP = AW'(SETTLE + 1);

  logic [AW-1:0] age;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (start_p) age <= '0;
    else if (run_q && age != ACAP) age <= age + AW'(1);
  end

  assert_stable_delay_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(clk_stable) |-> (age == AW'(SETTLE)));

  assert_stable_off_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ice_en |-> !clk_stable);

  assert_gate_needs_stable_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(gate_div) |-> $past(want));

  assert_gate_low_phase_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(gate_div) |-> !$past(phase_q));

  assert_div_hold_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(div_lat));
endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W), .SETTLE(SETTLE)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .ice_en(ice_en), .clk_stable(clk_stable),
  .start_p(start_p), .run_q(run_q), .div_lat(div_lat), .phase_q(phase_q),
  .gate_div(gate_div), .want(want)
);

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ice_en = 1'b0;
  logic        card_en = 1'b0;
  logic [9:0]  div_val = 10'd0;
  logic        clk_stable;
  logic        card_clk;
  logic [31:0] calc_target_hz = 32'd0;
  logic [9:0]  calc_div;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdclk_gen i_sdclk_gen (
    .ref_clk(clk), .rst_n(rst_n), .ice_en(ice_en), .card_en(card_en),
    .div_val(div_val), .clk_stable(clk_stable), .card_clk(card_clk),
    .calc_target_hz(calc_target_hz), .calc_div(calc_div)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input string req, input int n);
    int h = 0;
    int l = 0;
    int guard = 0;
    logic prev;
    prev = card_clk;
    @(negedge clk);
    while (!(prev == 1'b0 && card_clk == 1'b1) && guard < 4 * n + 20) begin
      prev = card_clk;
      @(negedge clk);
      guard++;
    end
    while (card_clk == 1'b1 && h < 4 * n) begin h++; @(negedge clk); end
    while (card_clk == 1'b0 && l < 4 * n) begin l++; @(negedge clk); end
    chk({req, " high cycles"}, h, n / 2);
    chk({req, " low cycles"}, l, n - n / 2);
  endtask

  task automatic start_clock(input int d);
    @(negedge clk); #1;
    ice_en = 1'b0; card_en = 1'b0;
    negs(2); #1;
    div_val = 10'(d); ice_en = 1'b1; card_en = 1'b1;
    negs(8);
  endtask

  task automatic t_reset;
    negs(2);
    chk("R1 stable in reset", int'(clk_stable), 0);
    chk("R1 card_clk in reset", int'(card_clk), 0);
    #1 rst_n = 1'b1;
    negs(3);
    chk("R1 stable after reset", int'(clk_stable), 0);
    chk("R1 card_clk after reset", int'(card_clk), 0);
  endtask

  task automatic t_settle;
    @(negedge clk); #1;
    ice_en = 1'b0; card_en = 1'b1; div_val = 10'd8;
    negs(2); #1;
    ice_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R4 not yet stable", int'(clk_stable), 0);
      chk("R6 card_clk low while unstable", int'(card_clk), 0);
    end
    @(negedge clk);
    chk("R4 stable after 4 cycles", int'(clk_stable), 1);
  endtask

  task automatic t_divide(input int n);
    start_clock(n);
    measure($sformatf("R2 div=%0d", n), n);
  endtask

  task automatic t_bypass(input int d);
    start_clock(d);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R3 bypass d=%0d high phase", d), int'(card_clk), 1);
      @(negedge clk); #1;
      chk($sformatf("R3 bypass d=%0d low phase", d), int'(card_clk), 0);
    end
  endtask

  task automatic t_drop;
    start_clock(4);
    @(negedge clk); #1;
    ice_en = 1'b0;
    #1 chk("R5 stable clears at once", int'(clk_stable), 0);
    negs(2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R5 card_clk low after stop", int'(card_clk), 0);
    end
  endtask

  task automatic t_hold;
    start_clock(4);
    #1 div_val = 10'd6;
    negs(10);
    measure("R8 divider held while running", 4);
    #1 ice_en = 1'b0;
    negs(2); #1;
    ice_en = 1'b1;
    negs(8);
    measure("R8 new divider after restart", 6);
  endtask

  task automatic t_glitch;
    int run = 0;
    int pulses = 0;
    @(negedge clk); #1;
    ice_en = 1'b0; card_en = 1'b0;
    negs(2); #1;
    div_val = 10'd8; ice_en = 1'b1;
    negs(10);
    fork
      begin
        for (int c = 0; c < 130; c++) begin
          @(negedge clk);
          if (card_clk) run++;
          else if (run != 0) begin
            chk("R7 full high pulse", run, 4);
            pulses++;
            run = 0;
          end
        end
      end
      begin
        negs(13); #1 card_en = 1'b1;
        negs(29); #1 card_en = 1'b0;
        negs(11); #1 card_en = 1'b1;
        negs(22); #1 card_en = 1'b0;
      end
    join
    chk("R7 pulses seen", int'(pulses >= 4), 1);
  endtask

  task automatic t_calc;
    int unsigned tgt [7] = '{400000, 0, 25000000, 52000000, 48000000, 50000, 200000000};
    int exp [7] = '{240, 0, 4, 2, 2, 1023, 0};
    for (int i = 0; i < 7; i++) begin
      calc_target_hz = tgt[i];
      #1 chk($sformatf("R9 target %0d Hz", tgt[i]), int'(calc_div), exp[i]);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_settle();
    t_divide(2);
    t_divide(3);
    t_divide(8);
    t_divide(240);
    t_bypass(1);
    t_bypass(0);
    t_drop();
    t_hold();
    t_glitch();
    t_calc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule